// File: doc/BRIEF.md
# Conditional instruction issue sequencer

This block paces instruction flow for a small 32-bit processor core with a 512-word register memory. It keeps a 9-bit program counter. In each issue cycle it captures the instruction word presented for that address and splits the word into its fields. It then tests the word's 4-bit predicate against the current Z and C flags. The outcome decides whether the instruction runs or is skipped.

Once the instruction is captured, the block counts out the cycles its class needs. For an instruction that runs, it pulses a write-back strobe in the final cycle of the slot. Hub-class instructions instead wait on an external arbiter. The arithmetic datapath, the register memory and the arbiter sit outside the block. They read the latched fields and react to the strobes.

The program counter advances at every issue. This lets the next word be fetched while the current slot is still counting down.

Top module: `cond_issue_seq`

## Requirements
- R1: A synchronous active-high reset sets `pc` to 0, drops `busy`, `hub_req` and `wb_strobe`, and leaves the block in its issue state, even if the reset arrives mid-slot.
- R2: Fields are taken from the word captured at issue and held unchanged for the whole slot, whatever `instr` does in the meantime. The field positions are: `op` = bits 31:26, `wz` = bit 25, `wc` = bit 24, `wr` = bit 23, `imm` = bit 22, `cond` = bits 21:18, `dst` = bits 17:9, `src` = bits 8:0.
- R3: `pc` increases by one, modulo 512, on the clock edge that ends each issue cycle. It holds at all other times.
- R4: The instruction runs when bit {C,Z} of `cond` is 1, with C as the upper index bit. This gives the following codes: 0 never, 1 NZ&NC, 2 Z&NC, 3 NC, 4 NZ&C, 5 NZ, 6 Z≠C, 7 NZ|NC, 8 Z&C, 9 Z=C, 10 Z, 11 Z|NC, 12 C, 13 NZ|C, 14 Z|C, 15 always.
- R5: A skipped instruction occupies 4 cycles from issue to the next issue, whatever its opcode. It raises no `wb_strobe`, `hub_req`, `src_rd` or `force_zc`.
- R6: Any executed opcode outside the hub, jump and reserved classes occupies 4 cycles. Its single `wb_strobe` falls in the last of them.
- R7: Executed opcodes 0 to 3 (hub class) spend 6 cycles before `hub_req` rises. `hub_req` then stays high until a cycle with `hub_ack`. That cycle carries the single `wb_strobe`, and the next cycle is an issue cycle.
- R8: Executed opcodes 57 to 59 (decrement/test jumps) occupy 4 cycles when `jump_hit` is high in the issue cycle, and 8 cycles otherwise. Each has one `wb_strobe` in its last cycle.
- R9: Executed opcodes 4 to 7 (reserved) occupy 4 cycles and have one `wb_strobe`. They hold `force_zc` high in every non-issue cycle of the slot, telling the datapath to write a zero result with Z=1 and C=1.
- R10: `src_rd` pulses for exactly one cycle, the cycle after issue, when the instruction runs and its `imm` bit is 0.
- R11: `busy` is high in every cycle of a slot except the issue cycle. `wb_strobe`, `src_rd` and `force_zc` occur only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word at address `pc`, sampled in the issue cycle |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| jump_hit | input | 1 | Jump test outcome from the datapath, sampled in the issue cycle; high selects the short slot |
| hub_ack | input | 1 | Arbiter grant ending the hub wait |
| pc | output | 9 | Program counter / fetch address |
| op | output | 6 | Latched opcode |
| cond | output | 4 | Latched predicate code |
| wz | output | 1 | Latched Z-write enable |
| wc | output | 1 | Latched C-write enable |
| wr | output | 1 | Latched result-write enable |
| imm | output | 1 | Latched immediate-source select |
| dst | output | 9 | Latched destination address |
| src | output | 9 | Latched source address or immediate |
| exec_ok | output | 1 | Latched predicate outcome for the current slot |
| src_rd | output | 1 | Register-memory source read strobe |
| hub_req | output | 1 | Hub access request |
| wb_strobe | output | 1 | Write-back strobe |
| force_zc | output | 1 | Reserved-opcode flag override |
| busy | output | 1 | High in every non-issue cycle |

## Verification
A wrong slot counter or class decode shows up as a gap between issues that is 4, 8 or 6-plus-wait cycles off. It is visible at `busy` within one slot, at most about nine cycles. A wrong predicate bit turns a strobe into silence, or silence into a strobe, in the fourth cycle of that same slot. The full sweep of all 16 codes against all four flag combinations exposes it within one instruction. A corrupted instruction latch or program counter appears on `op`, `dst`, `src` or `pc` on the edge after the issue. The mod-512 wrap needs a full lap of the counter to show.

// File: rtl/cond_issue_seq.sv
module cond_issue_seq #(
  parameter int ALU_CYC  = 4,
  parameter int HUB_PRE  = 6,
  parameter int JMP_LONG = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic        jump_hit,
  input  logic        hub_ack,
  output logic [8:0]  pc,
  output logic [5:0]  op,
  output logic [3:0]  cond,
  output logic        wz,
  output logic        wc,
  output logic        wr,
  output logic        imm,
  output logic [8:0]  dst,
  output logic [8:0]  src,
  output logic        exec_ok,
  output logic        src_rd,
  output logic        hub_req,
  output logic        wb_strobe,
  output logic        force_zc,
  output logic        busy
);
  localparam int MAXC = (JMP_LONG > HUB_PRE) ? JMP_LONG : HUB_PRE;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [1:0] K_ALU = 2'd0, K_HUB = 2'd1, K_JMP = 2'd2, K_RSV = 2'd3;

  typedef enum logic [1:0] {S_ISSUE, S_WAIT, S_HUB} st_t;

  st_t         st;
  logic [31:0] ir;
  logic [CW-1:0] cnt, len;
  logic [1:0]  kind, nkind;
  logic        exq, firstq;

  wire [5:0] nop   = instr[31:26];
  wire [3:0] ncond = instr[21:18];
  wire       nex   = ncond[{flag_c, flag_z}];

  always_comb begin
    if (nop <= 6'd3)                      nkind = K_HUB;
    else if (nop <= 6'd7)                 nkind = K_RSV;
    else if (nop >= 6'd57 && nop <= 6'd59) nkind = K_JMP;
    else                                  nkind = K_ALU;
  end

  always_comb begin
    len = CW'(ALU_CYC);
    if (nex) begin
      if (nkind == K_HUB)                  len = CW'(HUB_PRE);
      else if (nkind == K_JMP && !jump_hit) len = CW'(JMP_LONG);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_ISSUE;
      pc     <= '0;
      ir     <= '0;
      cnt    <= '0;
      kind   <= K_ALU;
      exq    <= 1'b0;
      firstq <= 1'b0;
    end else begin
      case (st)
        S_ISSUE: begin
          ir     <= instr;
          exq    <= nex;
          kind   <= nkind;
          cnt    <= len - CW'(1);
          firstq <= nex && !instr[22];
          pc     <= pc + 9'd1;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          firstq <= 1'b0;
          cnt    <= cnt - CW'(1);
          if (cnt == CW'(1))
            st <= (exq && kind == K_HUB) ? S_HUB : S_ISSUE;
        end
        S_HUB: if (hub_ack) st <= S_ISSUE;
        default: st <= S_ISSUE;
      endcase
    end
  end

  assign op   = ir[31:26];
  assign wz   = ir[25];
  assign wc   = ir[24];
  assign wr   = ir[23];
  assign imm  = ir[22];
  assign cond = ir[21:18];
  assign dst  = ir[17:9];
  assign src  = ir[8:0];

  assign exec_ok   = exq;
  assign busy      = (st != S_ISSUE);
  assign src_rd    = firstq;
  assign hub_req   = (st == S_HUB);
  assign force_zc  = busy && exq && kind == K_RSV;
  assign wb_strobe = (st == S_WAIT && cnt == CW'(1) && exq && kind != K_HUB) ||
                     (st == S_HUB && hub_ack);
endmodule

// File: rtl/cond_issue_seq_chk.sv
module cond_issue_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [8:0] pc,
  input logic       busy,
  input logic       wb_strobe,
  input logic       hub_req,
  input logic       hub_ack,
  input logic       force_zc,
  input logic       src_rd
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pc == 9'd0 && !busy && !hub_req));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> pc == $past(pc) + 9'd1);

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(pc));

  assert_wb_last_R6: assert property (@(posedge clk) disable iff (rst)
    wb_strobe |=> !busy);

  assert_hub_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (hub_req && !hub_ack) |=> hub_req);

  assert_force_R9: assert property (@(posedge clk) disable iff (rst)
    force_zc |-> (busy && !hub_req));

  assert_src_once_R10: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> !src_rd);

  assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (wb_strobe || src_rd) |-> busy);
endmodule

bind cond_issue_seq cond_issue_seq_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .busy(busy), .wb_strobe(wb_strobe),
  .hub_req(hub_req), .hub_ack(hub_ack), .force_zc(force_zc), .src_rd(src_rd)
);

// File: tb/tb_cond_issue_seq.sv
module tb_cond_issue_seq;
  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] instr = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0, jump_hit = 1'b0, hub_ack = 1'b0;
  logic [8:0]  pc, dst, src;
  logic [5:0]  op;
  logic [3:0]  cond;
  logic        wz, wc, wr, imm, exec_ok, src_rd, hub_req, wb_strobe, force_zc, busy;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cond_issue_seq dut (
    .clk(clk), .rst(rst), .instr(instr), .flag_z(flag_z), .flag_c(flag_c),
    .jump_hit(jump_hit), .hub_ack(hub_ack), .pc(pc), .op(op), .cond(cond),
    .wz(wz), .wc(wc), .wr(wr), .imm(imm), .dst(dst), .src(src),
    .exec_ok(exec_ok), .src_rd(src_rd), .hub_req(hub_req),
    .wb_strobe(wb_strobe), .force_zc(force_zc), .busy(busy)
  );

  // {word, {0,z,c,hit}, slot length, wb count, force cycles, src reads}
  localparam int NV = 14;
  localparam logic [51:0] VEC [NV] = '{
    {6'h20, 4'b0010, 4'hF, 9'd3,  9'd4,  4'b0000, 4'd4, 4'd1, 4'd0, 4'd1},
    {6'h20, 4'b0010, 4'h0, 9'd3,  9'd4,  4'b0000, 4'd4, 4'd0, 4'd0, 4'd0},
    {6'h21, 4'b0010, 4'hA, 9'd9,  9'd1,  4'b0100, 4'd4, 4'd1, 4'd0, 4'd1},
    {6'h21, 4'b0010, 4'hA, 9'd9,  9'd1,  4'b0000, 4'd4, 4'd0, 4'd0, 4'd0},
    {6'h18, 4'b0010, 4'h6, 9'd2,  9'd8,  4'b0100, 4'd4, 4'd1, 4'd0, 4'd1},
    {6'h18, 4'b0010, 4'h6, 9'd2,  9'd8,  4'b0110, 4'd4, 4'd0, 4'd0, 4'd0},
    {6'h02, 4'b0010, 4'hF, 9'd5,  9'd6,  4'b0000, 4'd9, 4'd1, 4'd0, 4'd1},
    {6'h00, 4'b0010, 4'h0, 9'd5,  9'd6,  4'b0000, 4'd4, 4'd0, 4'd0, 4'd0},
    {6'h39, 4'b0001, 4'hF, 9'd7,  9'd20, 4'b0001, 4'd4, 4'd1, 4'd0, 4'd0},
    {6'h39, 4'b0010, 4'hF, 9'd7,  9'd20, 4'b0000, 4'd8, 4'd1, 4'd0, 4'd1},
    {6'h3B, 4'b0010, 4'h0, 9'd7,  9'd20, 4'b0000, 4'd4, 4'd0, 4'd0, 4'd0},
    {6'h05, 4'b0010, 4'hF, 9'd11, 9'd12, 4'b0000, 4'd4, 4'd1, 4'd3, 4'd1},
    {6'h3A, 4'b0010, 4'h1, 9'd4,  9'd4,  4'b0000, 4'd8, 4'd1, 4'd0, 4'd1},
    {6'h03, 4'b0010, 4'hC, 9'd4,  9'd4,  4'b0010, 4'd9, 4'd1, 4'd0, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_exec(input logic [3:0] cd, input bit z, input bit c);
    case (cd)
      4'd0:  return 1'b0;
      4'd1:  return !z && !c;
      4'd2:  return z && !c;
      4'd3:  return !c;
      4'd4:  return !z && c;
      4'd5:  return !z;
      4'd6:  return z != c;
      4'd7:  return !z || !c;
      4'd8:  return z && c;
      4'd9:  return z == c;
      4'd10: return z;
      4'd11: return z || !c;
      4'd12: return c;
      4'd13: return !z || c;
      4'd14: return z || c;
      default: return 1'b1;
    endcase
  endfunction

  // Called at a negedge in an issue cycle; returns at the negedge of the next issue cycle.
  task automatic run_one(input logic [31:0] w, input bit z, input bit c, input bit hit,
                         output int cyc, output int wbn, output int frc, output int srn);
    int hw;
    logic [8:0] pc0;
    instr = w; flag_z = z; flag_c = c; jump_hit = hit;
    pc0 = pc; cyc = 1; wbn = 0; frc = 0; srn = 0; hw = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      if (!busy) break;
      cyc++;
      hub_ack = hub_req && (hw == 2);
      if (hub_req) hw++;
      #1;
      wbn += int'(wb_strobe);
      frc += int'(force_zc);
      srn += int'(src_rd);
    end
    hub_ack = 1'b0;
    chk(pc == pc0 + 9'd1, "R3 pc step", int'(pc), int'(pc0 + 9'd1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, wbn, frc, srn;
    logic [51:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc == 9'd0 && !busy && !hub_req && !wb_strobe, "R1 reset state", int'(pc), 0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run_one(v[51:20], v[18], v[17], v[16], cyc, wbn, frc, srn);
      chk(cyc == int'(v[15:12]), $sformatf("R5/R6/R7/R8/R11 slot length vec%0d", i), cyc, int'(v[15:12]));
      chk(wbn == int'(v[11:8]), $sformatf("R6/R7/R8 wb count vec%0d", i), wbn, int'(v[11:8]));
      chk(frc == int'(v[7:4]), $sformatf("R9 force cycles vec%0d", i), frc, int'(v[7:4]));
      chk(srn == int'(v[3:0]), $sformatf("R10 src reads vec%0d", i), srn, int'(v[3:0]));
    end

    // R4: every predicate against every flag pair
    for (int cd = 0; cd < 16; cd++) begin
      for (int f = 0; f < 4; f++) begin
        bit e;
        e = exp_exec(4'(cd), f[0], f[1]);
        run_one({6'h22, 4'b0010, 4'(cd), 9'd1, 9'd2}, f[0], f[1], 1'b0, cyc, wbn, frc, srn);
        chk(wbn == int'(e), $sformatf("R4 cond=%0d z=%0d c=%0d", cd, f[0], f[1]), wbn, int'(e));
        chk(exec_ok == e, "R4 exec_ok", int'(exec_ok), int'(e));
      end
    end

    // R2: fields latched and held while instr changes mid-slot
    instr = {6'h2A, 4'b1011, 4'hF, 9'h1A5, 9'h07B};
    flag_z = 1'b0; flag_c = 1'b0;
    @(posedge clk); @(negedge clk);
    instr = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    chk(op == 6'h2A, "R2 op held", int'(op), 'h2A);
    chk(wz && !wc && wr && imm, "R2 flag bits", int'({wz, wc, wr, imm}), 'b1011);
    chk(cond == 4'hF, "R2 cond", int'(cond), 15);
    chk(dst == 9'h1A5, "R2 dst", int'(dst), 'h1A5);
    chk(src == 9'h07B, "R2 src", int'(src), 'h07B);
    while (busy) @(negedge clk);

    // R3: full lap of the counter wraps to zero
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 512; k++)
      run_one({6'h20, 4'b0010, 4'h0, 9'd0, 9'd0}, 1'b0, 1'b0, 1'b0, cyc, wbn, frc, srn);
    chk(pc == 9'd0, "R3 wrap", int'(pc), 0);

    // R1: reset while waiting on the hub
    instr = {6'h01, 4'b0010, 4'hF, 9'd3, 9'd3};
    repeat (8) @(negedge clk);
    chk(hub_req == 1'b1, "R7 hub_req held without ack", int'(hub_req), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(pc == 9'd0 && !busy && !hub_req, "R1 mid-slot reset", int'(pc), 0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule